// File: doc/BRIEF.md
# Coherent Cache Node Controller

This block is the cache side of one node in a directory-coherent multiprocessor. It holds a small direct-mapped cache in which every line is invalid, shared or exclusive. A processor load or store that cannot be served from the cache becomes a miss message sent to the home node of the address. The processor is stalled until the matching data reply fills the line. Coherence commands that arrive from the network can demote or drop a line, and they can send its data back to the home node or forward it straight to the node that asked for it.

The controller is built around three named states. In `FS_IDLE` it serves hits and watches for misses. The transition *take_miss* leads to `FS_SEND`, where the miss message is driven for one cycle. The transition *sent* (the outgoing port is free) leads to `FS_WAIT`. The transition *reply_ok* (a data reply whose address equals the pending one) fills the line and returns to `FS_IDLE`. Answers to coherence commands are registered for one cycle. They take the outgoing port ahead of a miss message, which holds `FS_SEND` for that cycle.

Addresses are `ADDR_W` bits wide. The low `IDX_W` bits select the line, the remaining bits form the tag, and the top `NODE_W` bits name the home node.

Top module: `ccn_node`

## Requirements
- R1: A processor read whose line is invalid or holds another tag puts one single-cycle message on the outgoing port in the cycle after the request is first presented. The message has kind 0 (read miss), destination equal to the address's top `NODE_W` bits, source `MY_ID` and the request address.
- R2: A data reply (incoming kind 0) whose address equals the pending one fills the line as shared with the reply data. In the following cycle a held read is served with `cpu_stall` low and that data on `cpu_rdata`. A held read that hits is served without stall and without a message.
- R3: A fetch (incoming kind 1) to a matching exclusive line answers in the next cycle with kind 2 (write-back), destination the home node, and the line data, and leaves the line shared. A fetch to a shared line causes no message.
- R4: A fetch-invalidate (incoming kind 2) to a matching exclusive line answers in the next cycle with the line data and leaves the line invalid. With `three_hop` low the answer is kind 2 to the home node. With `three_hop` high it is kind 3 to the node on `in_node`.
- R5: A processor write to a line that is invalid, holds another tag or is only shared sends kind 1 (write miss) instead of kind 0.
- R6: `cpu_stall` is high from the cycle a miss is detected until the cycle after the matching reply. A reply whose address differs from the pending one is ignored.
- R7: A write-miss reply makes the line exclusive and holding the store data. A later write to an exclusive line completes without stall and without a message.
- R8: An invalidate (incoming kind 3) drops a matching line to invalid and sends no message.
- R9: A coherence command whose address tag differs from the stored tag, or whose line is invalid, sends nothing and leaves the line unchanged.
- R10: In any cycle a coherence command arrives, a processor request is stalled and does not touch the cache.
- R11: After reset every line is invalid, `cpu_stall` is low and no message is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| three_hop | input | 1 | Fetch-invalidate answers go to the requester instead of home |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | Access is a store |
| cpu_addr | input | ADDR_W | Access address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when not stalled |
| cpu_stall | output | 1 | Processor must hold its request |
| out_valid | output | 1 | Outgoing message valid |
| out_kind | output | 2 | 0 read miss, 1 write miss, 2 write-back, 3 forwarded data |
| out_dest | output | NODE_W | Destination node |
| out_src | output | NODE_W | This node's id |
| out_addr | output | ADDR_W | Line address |
| out_data | output | DATA_W | Line data (zero for misses) |
| in_valid | input | 1 | Incoming message valid |
| in_kind | input | 2 | 0 data reply, 1 fetch, 2 fetch-invalidate, 3 invalidate |
| in_node | input | NODE_W | Requesting node for forwarded data |
| in_addr | input | ADDR_W | Line address of the message |
| in_data | input | DATA_W | Reply data |

## Verification
The bench sends a reply to the wrong address first, so a design that ended its wait on any reply would release the stall early with stale data. A write to a shared line must give a write miss; a design that treated shared as writable would stay silent and let two copies diverge. Each fetch-invalidate is run in both routing modes, and the line is then re-read, to catch a misrouted answer or a line left shared. Commands with a mismatching tag, commands to a line already invalidated, and a command arriving beside a processor hit expose designs that act on index alone or let a store race a coherence change.

// File: rtl/ccn_pkg.sv
package ccn_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        OM_RD_MISS  = 2'd0,
        OM_WR_MISS  = 2'd1,
        OM_WRBACK   = 2'd2,
        OM_FWD_DATA = 2'd3
    } out_msg_e;

    typedef enum logic [1:0] {
        IM_REPLY     = 2'd0,
        IM_FETCH     = 2'd1,
        IM_FETCH_INV = 2'd2,
        IM_INVAL     = 2'd3
    } in_msg_e;
endpackage

// File: rtl/ccn_line_store.sv
module ccn_line_store
    import ccn_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output line_st_e          ra_state,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output line_st_e          rb_state,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  line_st_e          wa_state,
    input  logic [TAG_W-1:0]  wa_tag,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  line_st_e          wb_state
);
    localparam int LINES = 1 << IDX_W;

    line_st_e          st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i]  <= LN_INV;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end else if (wa_en && wa_idx == IDX_W'(i)) begin
                st_q[i]  <= wa_state;
                tag_q[i] <= wa_tag;
                dat_q[i] <= wa_data;
            end else if (wb_en && wb_idx == IDX_W'(i)) begin
                st_q[i]  <= wb_state;
            end
        end
    end

    assign ra_state = st_q[ra_idx];
    assign ra_tag   = tag_q[ra_idx];
    assign ra_data  = dat_q[ra_idx];
    assign rb_state = st_q[rb_idx];
    assign rb_tag   = tag_q[rb_idx];
    assign rb_data  = dat_q[rb_idx];

    // R10: processor-side and coherence-side writers never collide
    p_one_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wa_en && wb_en));
endmodule

// File: rtl/ccn_miss_fsm.sv
module ccn_miss_fsm
    import ccn_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    input  line_st_e                 line_state,
    input  logic [ADDR_W-IDX_W-1:0]  line_tag,
    input  logic                     snoop_now,
    input  logic                     out_busy,
    input  logic                     reply_valid,
    input  logic [ADDR_W-1:0]        reply_addr,
    input  logic [DATA_W-1:0]        reply_data,
    output logic                     cpu_stall,
    output logic                     miss_valid,
    output out_msg_e                 miss_kind,
    output logic [ADDR_W-1:0]        miss_addr,
    output logic                     wa_en,
    output logic [IDX_W-1:0]         wa_idx,
    output line_st_e                 wa_state,
    output logic [ADDR_W-IDX_W-1:0]  wa_tag,
    output logic [DATA_W-1:0]        wa_data
);
    typedef enum logic [1:0] {FS_IDLE, FS_SEND, FS_WAIT} fsm_e;

    fsm_e              st_q;
    logic [ADDR_W-1:0] pend_addr;
    logic              pend_we;
    logic [DATA_W-1:0] pend_wdata;
    logic              tag_eq, hit, take_miss, reply_ok;

    always_comb begin
        tag_eq    = (line_tag == cpu_addr[ADDR_W-1:IDX_W]);
        hit       = tag_eq && (cpu_we ? (line_state == LN_EXC) : (line_state != LN_INV));
        take_miss = (st_q == FS_IDLE) && cpu_req && !snoop_now && !hit;
        reply_ok  = (st_q == FS_WAIT) && reply_valid && (reply_addr == pend_addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= FS_IDLE;
            pend_addr  <= '0;
            pend_we    <= 1'b0;
            pend_wdata <= '0;
        end else begin
            unique case (st_q)
                FS_IDLE: if (take_miss) begin
                    st_q       <= FS_SEND;
                    pend_addr  <= cpu_addr;
                    pend_we    <= cpu_we;
                    pend_wdata <= cpu_wdata;
                end
                FS_SEND: if (!out_busy) st_q <= FS_WAIT;
                FS_WAIT: if (reply_ok) st_q <= FS_IDLE;
                default: st_q <= FS_IDLE;
            endcase
        end
    end

    always_comb begin
        cpu_stall  = 1'b0;
        miss_valid = 1'b0;
        wa_en      = 1'b0;
        wa_idx     = cpu_addr[IDX_W-1:0];
        wa_state   = LN_EXC;
        wa_tag     = cpu_addr[ADDR_W-1:IDX_W];
        wa_data    = cpu_wdata;
        unique case (st_q)
            FS_IDLE: begin
                cpu_stall = cpu_req && (snoop_now || !hit);
                wa_en     = cpu_req && cpu_we && hit && !snoop_now;
            end
            FS_SEND: begin
                cpu_stall  = 1'b1;
                miss_valid = 1'b1;
            end
            FS_WAIT: begin
                cpu_stall = 1'b1;
                if (reply_ok) begin
                    wa_en    = 1'b1;
                    wa_idx   = pend_addr[IDX_W-1:0];
                    wa_tag   = pend_addr[ADDR_W-1:IDX_W];
                    wa_state = pend_we ? LN_EXC : LN_SHR;
                    wa_data  = pend_we ? pend_wdata : reply_data;
                end
            end
            default: ;
        endcase
    end

    assign miss_kind = pend_we ? OM_WR_MISS : OM_RD_MISS;
    assign miss_addr = pend_addr;

    // R1: a miss message is a single pulse once the port is free
    p_send_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !out_busy) |=> !miss_valid);
    // R2: the matching reply returns the controller to idle
    p_fill_returns_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reply_ok |=> (st_q == FS_IDLE));
    // R6: stall holds while a miss is outstanding
    p_stall_until_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q != FS_IDLE) && !reply_ok) |=> cpu_stall);
endmodule

// File: rtl/ccn_snoop.sv
module ccn_snoop
    import ccn_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NODE_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  in_msg_e                  in_kind,
    input  logic [NODE_W-1:0]        in_node,
    input  logic [ADDR_W-1:0]        in_addr,
    input  logic                     three_hop,
    input  line_st_e                 line_state,
    input  logic [ADDR_W-IDX_W-1:0]  line_tag,
    input  logic [DATA_W-1:0]        line_data,
    output logic                     snoop_now,
    output logic                     wb_en,
    output line_st_e                 wb_state,
    output logic                     resp_valid,
    output out_msg_e                 resp_kind,
    output logic [NODE_W-1:0]        resp_dest,
    output logic [ADDR_W-1:0]        resp_addr,
    output logic [DATA_W-1:0]        resp_data
);
    logic              live, is_exc, send;
    out_msg_e          kind_d;
    logic [NODE_W-1:0] dest_d;

    always_comb begin
        snoop_now = in_valid && (in_kind != IM_REPLY);
        live      = (line_state != LN_INV) && (line_tag == in_addr[ADDR_W-1:IDX_W]);
        is_exc    = live && (line_state == LN_EXC);
        wb_en     = 1'b0;
        wb_state  = LN_INV;
        send      = 1'b0;
        kind_d    = OM_WRBACK;
        dest_d    = in_addr[ADDR_W-1 -: NODE_W];
        if (in_valid && live) begin
            unique case (in_kind)
                IM_FETCH: if (is_exc) begin
                    wb_en    = 1'b1;
                    wb_state = LN_SHR;
                    send     = 1'b1;
                end
                IM_FETCH_INV: begin
                    wb_en = 1'b1;
                    if (is_exc) begin
                        send = 1'b1;
                        if (three_hop) begin
                            kind_d = OM_FWD_DATA;
                            dest_d = in_node;
                        end
                    end
                end
                IM_INVAL: wb_en = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_kind  <= OM_WRBACK;
            resp_dest  <= '0;
            resp_addr  <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= send;
            if (send) begin
                resp_kind <= kind_d;
                resp_dest <= dest_d;
                resp_addr <= in_addr;
                resp_data <= line_data;
            end
        end
    end

    // R3: a fetch to an exclusive line is answered by a write-back
    p_fetch_answers_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == IM_FETCH && is_exc) |=> (resp_valid && resp_kind == OM_WRBACK));
    // R4: three-hop forwarding goes to the named requester
    p_three_hop_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == IM_FETCH_INV && is_exc && three_hop)
        |=> (resp_kind == OM_FWD_DATA && resp_dest == $past(in_node)));
    // R8: an invalidate never produces a message
    p_inval_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == IM_INVAL) |=> !resp_valid);
endmodule

// File: rtl/ccn_node.sv
module ccn_node
    import ccn_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NODE_W = 2,
    parameter int IDX_W  = 2,
    parameter int MY_ID  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              three_hop,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [NODE_W-1:0] out_dest,
    output logic [NODE_W-1:0] out_src,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [NODE_W-1:0] in_node,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_e          ra_state, rb_state, wa_state, wb_state;
    logic [TAG_W-1:0]  ra_tag, rb_tag, wa_tag;
    logic [DATA_W-1:0] rb_data, wa_data;
    logic [IDX_W-1:0]  wa_idx;
    logic              wa_en, wb_en, snoop_now;
    logic              miss_valid, resp_valid;
    out_msg_e          miss_kind, resp_kind;
    logic [ADDR_W-1:0] miss_addr, resp_addr;
    logic [NODE_W-1:0] resp_dest;
    logic [DATA_W-1:0] resp_data;
    in_msg_e           in_kind_e;

    assign in_kind_e = in_msg_e'(in_kind);

    ccn_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(cpu_addr[IDX_W-1:0]), .ra_state(ra_state), .ra_tag(ra_tag), .ra_data(cpu_rdata),
        .rb_idx(in_addr[IDX_W-1:0]), .rb_state(rb_state), .rb_tag(rb_tag), .rb_data(rb_data),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_state(wa_state), .wa_tag(wa_tag), .wa_data(wa_data),
        .wb_en(wb_en), .wb_idx(in_addr[IDX_W-1:0]), .wb_state(wb_state)
    );

    ccn_miss_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .line_state(ra_state), .line_tag(ra_tag),
        .snoop_now(snoop_now), .out_busy(resp_valid),
        .reply_valid(in_valid && in_kind_e == IM_REPLY), .reply_addr(in_addr), .reply_data(in_data),
        .cpu_stall(cpu_stall), .miss_valid(miss_valid), .miss_kind(miss_kind), .miss_addr(miss_addr),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_state(wa_state), .wa_tag(wa_tag), .wa_data(wa_data)
    );

    ccn_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NODE_W(NODE_W), .IDX_W(IDX_W)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_kind(in_kind_e), .in_node(in_node), .in_addr(in_addr),
        .three_hop(three_hop),
        .line_state(rb_state), .line_tag(rb_tag), .line_data(rb_data),
        .snoop_now(snoop_now), .wb_en(wb_en), .wb_state(wb_state),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_dest(resp_dest),
        .resp_addr(resp_addr), .resp_data(resp_data)
    );

    // coherence answers take the outgoing port ahead of a miss
    always_comb begin
        out_valid = resp_valid || miss_valid;
        out_src   = NODE_W'(MY_ID);
        if (resp_valid) begin
            out_kind = resp_kind;
            out_dest = resp_dest;
            out_addr = resp_addr;
            out_data = resp_data;
        end else begin
            out_kind = miss_kind;
            out_dest = miss_addr[ADDR_W-1 -: NODE_W];
            out_addr = miss_addr;
            out_data = '0;
        end
    end

    // R10: a processor request beside a coherence command is stalled
    p_snoop_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind != 2'd0 && cpu_req) |-> cpu_stall);
    // R11: nothing leaves the node in the first cycle after reset
    p_quiet_after_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/sim_ccn_node.sv
module sim_ccn_node;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       three_hop = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_stall;
    logic       out_valid;
    logic [1:0] out_kind, out_dest, out_src;
    logic [7:0] out_addr, out_data;
    logic       in_valid = 1'b0;
    logic [1:0] in_kind = '0, in_node = '0;
    logic [7:0] in_addr = '0, in_data = '0;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    ccn_node u0 (
        .clk(clk), .rst_n(rst_n), .three_hop(three_hop),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .out_valid(out_valid), .out_kind(out_kind), .out_dest(out_dest), .out_src(out_src),
        .out_addr(out_addr), .out_data(out_data),
        .in_valid(in_valid), .in_kind(in_kind), .in_node(in_node), .in_addr(in_addr), .in_data(in_data)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // full miss: request, message, optional stray reply, real reply, served
    task automatic do_miss(input logic [7:0] a, input logic we, input logic [7:0] wd,
                           input logic [7:0] rep, input logic stray);
        string rq;
        rq = we ? "R5" : "R1";
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1 chk("R6 stall on miss", int'(cpu_stall), 1);
        @(negedge clk);
        chk({rq, " valid"}, int'(out_valid), 1);
        chk({rq, " kind"}, int'(out_kind), we ? 1 : 0);
        chk({rq, " dest"}, int'(out_dest), int'(a[7:6]));
        chk({rq, " src"}, int'(out_src), 2);
        chk({rq, " addr"}, int'(out_addr), int'(a));
        @(negedge clk);
        chk("R1 single pulse", int'(out_valid), 0);
        chk("R6 stall waiting", int'(cpu_stall), 1);
        if (stray) begin
            in_valid = 1'b1; in_kind = 2'd0; in_addr = a ^ 8'h10; in_data = 8'hEE;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R6 stray reply ignored", int'(cpu_stall), 1);
        end
        in_valid = 1'b1; in_kind = 2'd0; in_addr = a; in_data = rep;
        @(negedge clk);
        in_valid = 1'b0;
        chk(we ? "R7 stall released" : "R2 stall released", int'(cpu_stall), 0);
        chk(we ? "R7 store data" : "R2 reply data", int'(cpu_rdata), int'(we ? wd : rep));
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic read_hit(input logic [7:0] a, input logic [7:0] exp, input string rq);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 chk({rq, " hit no stall"}, int'(cpu_stall), 0);
        chk({rq, " hit data"}, int'(cpu_rdata), int'(exp));
        @(negedge clk);
        chk({rq, " hit silent"}, int'(out_valid), 0);
        cpu_req = 1'b0;
    endtask

    task automatic write_hit(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        #1 chk("R7 write hit no stall", int'(cpu_stall), 0);
        @(negedge clk);
        chk("R7 write hit silent", int'(out_valid), 0);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] k, input logic [7:0] a, input logic [1:0] nd,
                         input logic th, input logic exp_v, input logic [1:0] exp_k,
                         input logic [1:0] exp_d, input logic [7:0] exp_data, input string rq);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_addr = a; in_node = nd; three_hop = th;
        @(negedge clk);
        in_valid = 1'b0; three_hop = 1'b0;
        chk({rq, " answer valid"}, int'(out_valid), int'(exp_v));
        if (exp_v) begin
            chk({rq, " answer kind"}, int'(out_kind), int'(exp_k));
            chk({rq, " answer dest"}, int'(out_dest), int'(exp_d));
            chk({rq, " answer addr"}, int'(out_addr), int'(a));
            chk({rq, " answer data"}, int'(out_data), int'(exp_data));
        end
    endtask

    task automatic snoop_beside_hit(input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        in_valid = 1'b1; in_kind = 2'd1; in_addr = 8'hC7; in_node = 2'd0;
        #1 chk("R10 stall beside command", int'(cpu_stall), 1);
        @(negedge clk);
        in_valid = 1'b0;
        #1 chk("R10 released after command", int'(cpu_stall), 0);
        chk("R10 data intact", int'(cpu_rdata), int'(exp));
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset stall", int'(cpu_stall), 0);
        chk("R11 reset quiet", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 quiet after reset", int'(out_valid), 0);

        // read miss with a stray reply first (R1, R2, R6)
        do_miss(8'h45, 1'b0, 8'h00, 8'h3C, 1'b1);
        read_hit(8'h45, 8'h3C, "R2");
        // fetch to a shared line is silent (R3)
        snoop(2'd1, 8'h45, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00, "R3 shared");
        // write to shared line upgrades (R5, R7)
        do_miss(8'h45, 1'b1, 8'h5A, 8'h99, 1'b0);
        write_hit(8'h45, 8'h6B);
        read_hit(8'h45, 8'h6B, "R7");
        // fetch demotes exclusive to shared (R3)
        snoop(2'd1, 8'h45, 2'd0, 1'b0, 1'b1, 2'd2, 2'd1, 8'h6B, "R3");
        read_hit(8'h45, 8'h6B, "R3");
        do_miss(8'h45, 1'b1, 8'h11, 8'h00, 1'b0);
        // four-hop fetch-invalidate (R4)
        snoop(2'd2, 8'h45, 2'd0, 1'b0, 1'b1, 2'd2, 2'd1, 8'h11, "R4 home");
        do_miss(8'h45, 1'b0, 8'h00, 8'h22, 1'b0);
        // three-hop fetch-invalidate (R4)
        do_miss(8'hC7, 1'b1, 8'h77, 8'h00, 1'b0);
        snoop(2'd2, 8'hC7, 2'd0, 1'b1, 1'b1, 2'd3, 2'd0, 8'h77, "R4 forward");
        snoop(2'd1, 8'hC7, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00, "R4 line dropped");
        // invalidate of shared line (R8)
        snoop(2'd3, 8'h45, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00, "R8");
        do_miss(8'h45, 1'b0, 8'h00, 8'h33, 1'b0);
        // mismatching tag leaves the line alone (R9)
        snoop(2'd3, 8'h05, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00, "R9");
        read_hit(8'h45, 8'h33, "R9");
        // command beside a processor hit (R10)
        snoop_beside_hit(8'h45, 8'h33);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule